// File: doc/BRIEF.md
# Sampling Multiplexer Sequencer

The sequencer paces the analog front end of a single delta-sigma converter from a 32768 Hz clock-enable pulse (`tick`). Each pass visits a configurable number of input channels in ascending order. For each channel it starts a conversion and holds the multiplexer select on that channel. When the conversion ends, it issues a store strobe whose address is derived from the channel. After the last conversion of a pass comes one idle slot. In that slot the sequencer pulses a start to the downstream computation engine and flips the reference-chop control.

A 2-bit channel code and a 1-bit length select set the pass shape. Both are sampled only at pass boundaries. A rising edge on the alternate request is synchronised and remembered. The next pass then runs as an alternate pass, flagged for its whole duration, and only that one pass. An illegal channel code runs as four channels and raises a sticky error flag.

Top module: `smux_seq`

## Requirements
- R1: Channel code 2'b01 selects 4 channels, 2'b10 selects 3 and 2'b11 selects 2. Within a pass, `mux_sel` steps 0,1,… up to the last channel and holds the last channel through the idle slot.
- R2: A conversion lasts 2 ticks when `long_conv` is 0 and 3 ticks when it is 1. `conv_start` pulses once at the start of each conversion.
- R3: A pass lasts channels × conversion-ticks + 1 ticks. For 4/3/2 channels this is 9/7/5 ticks with `long_conv`=0 and 13/10/7 ticks with `long_conv`=1.
- R4: At the end of every conversion, `store_stb` pulses for one clock. In that clock `store_addr` equals ADDR_BASE plus the channel just converted. `store_addr` holds between strobes.
- R5: `eng_start` pulses for one clock on entry to the idle slot that follows the last conversion, once per pass, and never together with `conv_start`.
- R6: `ref_chop` toggles exactly in the clocks where `eng_start` pulses and is otherwise stable.
- R7: A rising edge on `alt_req` makes the next pass that begins after the edge has passed the synchroniser an alternate pass. `alt_active` is high for all of that pass and low for the following one. A request held for one clock still counts. Several edges within one pass yield one alternate pass.
- R8: Channel code 2'b00 runs the pass as 4 channels and sets `cfg_err`, which stays set until reset.
- R9: A change of `chan_code` or `long_conv` during a pass does not alter that pass. It applies from the next pass boundary.
- R10: In reset and until the first tick, all outputs are 0. The first tick after reset starts a pass on channel 0.
- R11: `conv_start`, `store_stb` and `eng_start` are one-clock pulses that appear only in the clock after a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32768 Hz clock-enable, one clock wide |
| chan_code | input | 2 | Channel-count code, sampled at pass boundary |
| long_conv | input | 1 | Conversion length select (0: 2 ticks, 1: 3 ticks) |
| alt_req | input | 1 | Asynchronous alternate-pass request, rising-edge armed |
| mux_sel | output | $clog2(MAX_CH) | Analog multiplexer channel select |
| conv_start | output | 1 | Conversion start pulse to the converter |
| store_stb | output | 1 | Result store strobe |
| store_addr | output | ADDR_W | Result store address |
| eng_start | output | 1 | Computation-engine pass start pulse |
| ref_chop | output | 1 | Reference chopping control |
| alt_active | output | 1 | High for the duration of an alternate pass |
| cfg_err | output | 1 | Sticky illegal-channel-code flag |

## Verification
A corrupted slot or channel counter shows up within one tick as a misplaced `conv_start`, `store_stb` or `mux_sel` value. A wrong pass-length latch shifts `eng_start` and the chop toggle by at least one tick within the same pass. A lost or duplicated alternate request appears at the next pass boundary as a wrong `alt_active` level, so the per-clock reference comparison catches it at most one pass after the request. Measured pass lengths for all six legal settings pin down any error in the channel-code or length decode.

// File: rtl/smux_pkg.sv
package smux_pkg;

   // number of channels visited per pass for a channel code
   function automatic int unsigned chans_for(input logic [1:0] code,
                                             input int unsigned max_ch);
      if (code == 2'b00) return max_ch;
      return max_ch + 1 - int'(code);
   endfunction

   // code 00 is the illegal setting
   function automatic logic code_bad(input logic [1:0] code);
      return code == 2'b00;
   endfunction

endpackage

// File: rtl/smux_cfg_dec.sv
module smux_cfg_dec #(
   parameter int unsigned MAX_CH    = 4,
   parameter int unsigned SHORT_LEN = 2,
   parameter int unsigned LONG_LEN  = 3,
   localparam int unsigned CH_W     = $clog2(MAX_CH),
   localparam int unsigned SUB_W    = $clog2(LONG_LEN)
) (
   input  logic [1:0]       chan_code,
   input  logic             long_conv,
   output logic [CH_W-1:0]  last_ch,
   output logic [SUB_W-1:0] last_sub,
   output logic             bad
);
   import smux_pkg::*;

   always_comb begin
      last_ch  = CH_W'(chans_for(chan_code, MAX_CH) - 1);
      last_sub = long_conv ? SUB_W'(LONG_LEN - 1) : SUB_W'(SHORT_LEN - 1);
      bad      = code_bad(chan_code);
   end
endmodule

// File: rtl/smux_alt_arm.sv
module smux_alt_arm #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alt_req,
   input  logic boundary,
   output logic alt_active
);
   logic req_s;
   logic req_prev;
   logic armed;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign req_s = alt_req;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], alt_req};
         end
         assign req_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = req_s & ~req_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_prev   <= 1'b0;
         armed      <= 1'b0;
         alt_active <= 1'b0;
      end else begin
         req_prev <= req_s;
         if (boundary) begin
            alt_active <= armed;
            armed      <= rise;
         end else begin
            armed <= armed | rise;
         end
      end
   end
endmodule

// File: rtl/smux_core.sv
module smux_core #(
   parameter int unsigned MAX_CH    = 4,
   parameter int unsigned LONG_LEN  = 3,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned ADDR_BASE = 0,
   localparam int unsigned CH_W     = $clog2(MAX_CH),
   localparam int unsigned SUB_W    = $clog2(LONG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CH_W-1:0]   last_ch_in,
   input  logic [SUB_W-1:0]  last_sub_in,
   input  logic              bad_in,
   output logic              boundary,
   output logic [CH_W-1:0]   mux_sel,
   output logic              conv_start,
   output logic              store_stb,
   output logic [ADDR_W-1:0] store_addr,
   output logic              eng_start,
   output logic              ref_chop,
   output logic              cfg_err
);
   logic             idle;
   logic [SUB_W-1:0] sub;
   logic [CH_W-1:0]  lc_q;
   logic [SUB_W-1:0] ls_q;

   assign boundary = tick & idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle       <= 1'b1;
         mux_sel    <= '0;
         sub        <= '0;
         lc_q       <= '0;
         ls_q       <= '0;
         conv_start <= 1'b0;
         store_stb  <= 1'b0;
         store_addr <= '0;
         eng_start  <= 1'b0;
         ref_chop   <= 1'b0;
         cfg_err    <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         store_stb  <= 1'b0;
         eng_start  <= 1'b0;
         if (tick) begin
            if (idle) begin
               idle       <= 1'b0;
               mux_sel    <= '0;
               sub        <= '0;
               lc_q       <= last_ch_in;
               ls_q       <= last_sub_in;
               conv_start <= 1'b1;
               if (bad_in) cfg_err <= 1'b1;
            end else if (sub == ls_q) begin
               store_stb  <= 1'b1;
               store_addr <= ADDR_W'(ADDR_BASE) + ADDR_W'(mux_sel);
               if (mux_sel == lc_q) begin
                  idle      <= 1'b1;
                  eng_start <= 1'b1;
                  ref_chop  <= ~ref_chop;
               end else begin
                  mux_sel    <= mux_sel + 1'b1;
                  sub        <= '0;
                  conv_start <= 1'b1;
               end
            end else begin
               sub <= sub + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/smux_seq.sv
module smux_seq #(
   parameter int unsigned MAX_CH      = 4,
   parameter int unsigned SHORT_LEN   = 2,
   parameter int unsigned LONG_LEN    = 3,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned ADDR_BASE   = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic [1:0]                chan_code,
   input  logic                      long_conv,
   input  logic                      alt_req,
   output logic [$clog2(MAX_CH)-1:0] mux_sel,
   output logic                      conv_start,
   output logic                      store_stb,
   output logic [ADDR_W-1:0]         store_addr,
   output logic                      eng_start,
   output logic                      ref_chop,
   output logic                      alt_active,
   output logic                      cfg_err
);
   localparam int unsigned CH_W  = $clog2(MAX_CH);
   localparam int unsigned SUB_W = $clog2(LONG_LEN);

   generate
      if (MAX_CH < 3) begin : g_bad_ch
         $error("smux_seq: MAX_CH must be at least 3");
      end
      if (SHORT_LEN < 1 || SHORT_LEN > LONG_LEN || LONG_LEN < 2) begin : g_bad_len
         $error("smux_seq: need 1 <= SHORT_LEN <= LONG_LEN and LONG_LEN >= 2");
      end
      if (ADDR_BASE + MAX_CH > (1 << ADDR_W)) begin : g_bad_addr
         $error("smux_seq: store address range exceeds ADDR_W");
      end
   endgenerate

   logic [CH_W-1:0]  last_ch;
   logic [SUB_W-1:0] last_sub;
   logic             bad;
   logic             boundary;

   smux_cfg_dec #(.MAX_CH(MAX_CH), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dec (
      .chan_code (chan_code),
      .long_conv (long_conv),
      .last_ch   (last_ch),
      .last_sub  (last_sub),
      .bad       (bad)
   );

   smux_core #(.MAX_CH(MAX_CH), .LONG_LEN(LONG_LEN), .ADDR_W(ADDR_W),
               .ADDR_BASE(ADDR_BASE)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .last_ch_in  (last_ch),
      .last_sub_in (last_sub),
      .bad_in      (bad),
      .boundary    (boundary),
      .mux_sel     (mux_sel),
      .conv_start  (conv_start),
      .store_stb   (store_stb),
      .store_addr  (store_addr),
      .eng_start   (eng_start),
      .ref_chop    (ref_chop),
      .cfg_err     (cfg_err)
   );

   smux_alt_arm #(.SYNC_STAGES(SYNC_STAGES)) u_alt (
      .clk        (clk),
      .rst_n      (rst_n),
      .alt_req    (alt_req),
      .boundary   (boundary),
      .alt_active (alt_active)
   );
endmodule

// File: rtl/smux_seq_chk.sv
module smux_seq_chk #(
   parameter int unsigned MAX_CH    = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned ADDR_BASE = 0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      tick,
   input logic [$clog2(MAX_CH)-1:0] mux_sel,
   input logic                      conv_start,
   input logic                      store_stb,
   input logic [ADDR_W-1:0]         store_addr,
   input logic                      eng_start,
   input logic                      ref_chop,
   input logic                      alt_active,
   input logic                      cfg_err
);
   // R11
   pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start | store_stb | eng_start) |-> $past(tick));

   // R1
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mux_sel) <= int'(MAX_CH) - 1);

   // R4
   store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_stb |-> (int'(store_addr) == int'(ADDR_BASE) + int'($past(mux_sel))));

   // R5
   eng_no_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !conv_start);

   // R6
   chop_only_on_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_chop != $past(ref_chop)) |-> eng_start);

   // R6
   chop_on_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (ref_chop != $past(ref_chop)));

   // R7
   alt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_active != $past(alt_active)) |-> (conv_start && mux_sel == '0));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_err) |-> cfg_err);
endmodule

bind smux_seq smux_seq_chk #(.MAX_CH(MAX_CH), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .mux_sel    (mux_sel),
   .conv_start (conv_start),
   .store_stb  (store_stb),
   .store_addr (store_addr),
   .eng_start  (eng_start),
   .ref_chop   (ref_chop),
   .alt_active (alt_active),
   .cfg_err    (cfg_err)
);

// File: tb/smux_seq_tb.sv
module smux_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] chan_code = 2'b01;
   logic       long_conv = 1'b0;
   logic       alt_req = 1'b0;
   logic [1:0] mux_sel;
   logic       conv_start, store_stb, eng_start, ref_chop, alt_active, cfg_err;
   logic [3:0] store_addr;

   int checks = 0;
   int errors = 0;
   int tick_cnt = 0;
   int div = 0;

   always #5 clk = ~clk;

   smux_seq u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .chan_code(chan_code),
      .long_conv(long_conv), .alt_req(alt_req), .mux_sel(mux_sel),
      .conv_start(conv_start), .store_stb(store_stb), .store_addr(store_addr),
      .eng_start(eng_start), .ref_chop(ref_chop), .alt_active(alt_active),
      .cfg_err(cfg_err)
   );

   // tick one clock in three, changed away from the active edge
   always @(negedge clk) begin
      div  = (div == 2) ? 0 : div + 1;
      tick = (div == 2);
   end
   always @(posedge clk) if (tick && rst_n) tick_cnt <= tick_cnt + 1;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  pos, n_ch, c_len;
   bit  m_idle, m_pend, m_s0, m_s1, m_prev, rise;
   int  e_sel, e_addr;
   bit  e_conv, e_stb, e_eng, e_chop, e_alt, e_err;
   bit  model_on = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = 1; m_pend = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
         e_sel = 0; e_addr = 0; e_conv = 0; e_stb = 0; e_eng = 0;
         e_chop = 0; e_alt = 0; e_err = 0; pos = 0; n_ch = 4; c_len = 2;
      end else begin
         rise = m_s1 && !m_prev;
         m_prev = m_s1; m_s1 = m_s0; m_s0 = alt_req;
         e_conv = 0; e_stb = 0; e_eng = 0;
         if (tick && m_idle) begin
            m_idle = 0; pos = 0;
            n_ch  = (chan_code == 2'b00) ? 4 : 5 - int'(chan_code);
            c_len = long_conv ? 3 : 2;
            if (chan_code == 2'b00) e_err = 1;
            e_conv = 1; e_sel = 0;
            e_alt = m_pend; m_pend = rise;
         end else begin
            if (tick) begin
               pos++;
               if (pos % c_len == 0) begin e_stb = 1; e_addr = pos / c_len - 1; end
               if (pos == n_ch * c_len) begin
                  m_idle = 1; e_eng = 1; e_chop = !e_chop;
               end else begin
                  e_sel = pos / c_len;
                  if (pos % c_len == 0) e_conv = 1;
               end
            end
            m_pend = m_pend | rise;
         end
      end
   end

   always @(posedge clk) begin
      #2;
      if (model_on) begin
         chk("R1 mux_sel", mux_sel, e_sel);
         chk("R2/R11 conv_start", conv_start, e_conv);
         chk("R4/R11 store_stb", store_stb, e_stb);
         chk("R4 store_addr", store_addr, e_addr);
         chk("R5/R11 eng_start", eng_start, e_eng);
         chk("R6 ref_chop", ref_chop, e_chop);
         chk("R7 alt_active", alt_active, e_alt);
         chk("R8 cfg_err", cfg_err, e_err);
      end
   end

   // ---------------- directed sequences ----------------
   task automatic wait_eng(output int t);
      @(posedge clk); #2;
      while (!eng_start) begin @(posedge clk); #2; end
      t = tick_cnt;
   endtask

   task automatic measure(input logic [1:0] code, input logic lng, input int exp_len,
                          input string req);
      int t0, t1, t2;
      chan_code = code; long_conv = lng;
      wait_eng(t0);   // pass that was running at the change
      wait_eng(t1);   // first pass with the new setting
      wait_eng(t2);
      chk(req, t2 - t1, exp_len);
      chk(req, t1 - t0, exp_len);
   endtask

   initial begin
      int t0, t1, alt_cnt;
      repeat (4) @(posedge clk);
      #2;
      // R10: reset values
      chk("R10 reset mux_sel", mux_sel, 0);
      chk("R10 reset pulses", {conv_start, store_stb, eng_start}, 0);
      chk("R10 reset flags", {ref_chop, alt_active, cfg_err}, 0);
      @(negedge clk); rst_n = 1'b1;
      model_on = 1'b1;

      // R3 / R1 / R2: all six legal settings
      measure(2'b01, 1'b0, 9,  "R3 4ch short");
      measure(2'b10, 1'b0, 7,  "R3 3ch short");
      measure(2'b11, 1'b0, 5,  "R3 2ch short");
      measure(2'b01, 1'b1, 13, "R3 4ch long");
      measure(2'b10, 1'b1, 10, "R3 3ch long");
      measure(2'b11, 1'b1, 7,  "R3 2ch long");

      // R9: change mid-pass, current pass keeps old length (2ch long = 7)
      wait_eng(t0);
      repeat (6) @(posedge clk);
      chan_code = 2'b01; long_conv = 1'b0;
      wait_eng(t1);
      chk("R9 old pass length kept", t1 - t0, 7);
      wait_eng(t0);
      chk("R9 new pass length", t0 - t1, 9);

      // R7: one-clock request inside a pass -> exactly one alternate pass
      repeat (7) @(posedge clk);
      @(negedge clk) alt_req = 1'b1;
      @(negedge clk) alt_req = 1'b0;
      alt_cnt = 0;
      for (int i = 0; i < 4; i++) begin
         wait_eng(t0);
         if (alt_active) alt_cnt++;
      end
      chk("R7 single short request", alt_cnt, 1);

      // R7: two edges in one pass still give a single alternate pass
      wait_eng(t0);
      @(negedge clk) alt_req = 1'b1;
      @(negedge clk) alt_req = 1'b0;
      repeat (3) @(negedge clk);
      alt_req = 1'b1;
      repeat (2) @(negedge clk);
      alt_req = 1'b0;
      alt_cnt = 0;
      for (int i = 0; i < 4; i++) begin
         wait_eng(t0);
         if (alt_active) alt_cnt++;
      end
      chk("R7 merged requests", alt_cnt, 1);

      // R8: illegal code runs 4 channels and sets the sticky flag
      chk("R8 flag clear before", cfg_err, 0);
      measure(2'b00, 1'b0, 9, "R8 code00 as 4ch");
      chk("R8 flag set", cfg_err, 1);
      measure(2'b11, 1'b0, 5, "R8 legal again");
      chk("R8 flag sticky", cfg_err, 1);

      model_on = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule